// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

A synchronous real-time clock core that advances once for every cycle on which a 100 Hz tick enable is high. It holds the time and calendar in eight 8-bit BCD registers: hundredths, seconds, minutes, hours, day of week, date, month and year. The hours register carries its own format select, so the same counter runs as a 24-hour clock or as a 12-hour clock with a PM flag. Month lengths come from the month and year, with a leap February whenever the two-digit year is a multiple of four, which is correct through the year 2099.

A host loads all eight registers as one 64-bit word and reads them back the same way. Two control bits in the day register halt timekeeping and choose whether an external active-low reset request is passed on as a transfer-abort signal to the host logic. That request never changes the time registers. Producing the tick from a crystal and all power handling sit outside this block.

The register word packs register n at bits 8n+7 down to 8n: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year.

Top module: `rtc_core`

## Requirements
- R1: After reset the word reads 64'h00_01_01_31_00_00_00_00 (year 00, month 01, date 01, day 1 with both control bits 1, 24-hour 00:00:00.00), and abort_o is 0 even with ext_rst_n_i low.
- R2: Each accepted tick adds one to hundredths in BCD (09 to 10); hundredths 99 wraps to 00 and carries into seconds, seconds and minutes wrap 59 to 00 with a carry, and with no tick and no load the word holds.
- R3: With hours bit 7 at 0 (24-hour), hours count 00 to 23 using bit 5 as the tens bit for 20 to 23 (19 to 20, 09 to 10), and 23 wraps to 00 with a carry into the calendar.
- R4: With hours bit 7 at 1 (12-hour), bits 4:0 count 12, 01 to 11 and bit 5 is PM; 11 to 12 flips PM, 12 goes to 01 keeping PM, and 11 PM to 12 AM carries into the calendar.
- R5: The date wraps to 01 after 30 in months 04, 06, 09, 11, after 31 in other months, and after 28 in month 02 unless the BCD year is a multiple of four (including 00), then after 29; month 12 wraps to 01 carrying into the year, and year 99 wraps to 00.
- R6: Day of week (day bits 2:0) advances with each date carry and wraps from 7 to 1.
- R7: When day bit 5 is 1, ticks are ignored and the word holds.
- R8: When day bit 4 is 0 and ext_rst_n_i is low, abort_o is 1; when day bit 4 is 1, abort_o is 0; ext_rst_n_i never changes the word.
- R9: A load writes all eight registers in one cycle; a tick in the same cycle is discarded.
- R10: Unused bits read 0: seconds and minutes bit 7, hours bit 6, day bits 7, 6, 3, date bits 7:6, month bits 7:5; written values there are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 100 Hz advance enable, one cycle per step |
| ext_rst_n_i | input | 1 | External active-low transfer reset request |
| load_i | input | 1 | Load all registers from load_data_i |
| load_data_i | input | 64 | Register word to load |
| rd_data_o | output | 64 | Current register word |
| abort_o | output | 1 | Transfer abort to host logic |

## Verification
The bench builds the core with its default seven-day week, so the weekday wrap from 7 to 1 is reached by a single tick from a preloaded end-of-day state. Because every register can be preloaded, each rollover (hour format edges, short months, leap and non-leap Februaries with even and odd year tens, year end) is reached in one tick rather than by counting through real time.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int unsigned NREG  = 8;
    localparam int unsigned REG_W = 8;
    localparam int unsigned BUS_W = NREG * REG_W;

    localparam int unsigned HR_MODE_BIT = 7;
    localparam int unsigned HR_PM_BIT   = 5;
    localparam int unsigned DAY_OSC_BIT = 5;
    localparam int unsigned DAY_RST_BIT = 4;

    localparam logic [BUS_W-1:0] WR_MASK = 64'hFF_1F_3F_37_BF_7F_7F_FF;

    typedef struct packed {
        logic [REG_W-1:0] year;
        logic [REG_W-1:0] month;
        logic [REG_W-1:0] date;
        logic [REG_W-1:0] day;
        logic [REG_W-1:0] hours;
        logic [REG_W-1:0] minutes;
        logic [REG_W-1:0] seconds;
        logic [REG_W-1:0] hundredths;
    } rtc_regs_t;

    localparam rtc_regs_t RESET_REGS = 64'h00_01_01_31_00_00_00_00;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
        else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
    endfunction
endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len (
    input  logic [7:0] month_i,
    input  logic [7:0] year_i,
    output logic [7:0] last_date_o
);
    logic leap;

    always_comb begin
        if (year_i[4]) leap = (year_i[3:0] == 4'd2) || (year_i[3:0] == 4'd6);
        else           leap = (year_i[3:0] == 4'd0) || (year_i[3:0] == 4'd4) ||
                              (year_i[3:0] == 4'd8);
        case (month_i)
            8'h02:                      last_date_o = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date_o = 8'h30;
            default:                    last_date_o = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
    import rtc_pkg::*;
(
    input  logic [7:0] hour_i,
    output logic [7:0] hour_o,
    output logic       day_carry_o
);
    logic [4:0] h12;
    logic       pm;

    always_comb begin
        h12         = hour_i[4:0];
        pm          = hour_i[HR_PM_BIT];
        day_carry_o = 1'b0;
        if (hour_i[HR_MODE_BIT]) begin
            if (h12 == 5'h11) begin
                hour_o      = {2'b10, ~pm, 5'h12};
                day_carry_o = pm;
            end else if (h12 == 5'h12) begin
                hour_o = {2'b10, pm, 5'h01};
            end else if (h12[3:0] == 4'd9) begin
                hour_o = {2'b10, pm, 5'h10};
            end else begin
                hour_o = {2'b10, pm, h12[4], h12[3:0] + 4'd1};
            end
        end else begin
            if (hour_i[5:0] == 6'h23) begin
                hour_o      = 8'h00;
                day_carry_o = 1'b1;
            end else if (hour_i[3:0] == 4'd9) begin
                hour_o = {2'b00, hour_i[5:4] + 2'd1, 4'd0};
            end else begin
                hour_o = {2'b00, hour_i[5:4], hour_i[3:0] + 4'd1};
            end
        end
    end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int unsigned DOW_LAST = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             ext_rst_n_i,
    input  logic             load_i,
    input  logic [BUS_W-1:0] load_data_i,
    output logic [BUS_W-1:0] rd_data_o,
    output logic             abort_o
);
    localparam logic [2:0] DOW_END = 3'(DOW_LAST);

    rtc_regs_t  state_d, state_q;
    logic [7:0] hour_next, last_date;
    logic       hour_day_carry;
    logic       osc_stop_q;

    rtc_hour_step u_hour (
        .hour_i     (state_q.hours),
        .hour_o     (hour_next),
        .day_carry_o(hour_day_carry)
    );

    rtc_month_len u_mlen (
        .month_i    (state_q.month),
        .year_i     (state_q.year),
        .last_date_o(last_date)
    );

    assign osc_stop_q = state_q.day[DAY_OSC_BIT];

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = rtc_regs_t'(load_data_i & WR_MASK);
        end else if (tick_i && !osc_stop_q) begin
            if (state_q.hundredths != 8'h99) begin
                state_d.hundredths = bcd_inc(state_q.hundredths);
            end else begin
                state_d.hundredths = 8'h00;
                if (state_q.seconds != 8'h59) begin
                    state_d.seconds = bcd_inc(state_q.seconds);
                end else begin
                    state_d.seconds = 8'h00;
                    if (state_q.minutes != 8'h59) begin
                        state_d.minutes = bcd_inc(state_q.minutes);
                    end else begin
                        state_d.minutes = 8'h00;
                        state_d.hours   = hour_next;
                        if (hour_day_carry) begin
                            if (state_q.day[2:0] == DOW_END) state_d.day[2:0] = 3'd1;
                            else state_d.day[2:0] = state_q.day[2:0] + 3'd1;
                            if (state_q.date != last_date) begin
                                state_d.date = bcd_inc(state_q.date);
                            end else begin
                                state_d.date = 8'h01;
                                if (state_q.month != 8'h12) begin
                                    state_d.month = bcd_inc(state_q.month);
                                end else begin
                                    state_d.month = 8'h01;
                                    if (state_q.year == 8'h99) state_d.year = 8'h00;
                                    else state_d.year = bcd_inc(state_q.year);
                                end
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= RESET_REGS;
        else         state_q <= state_d;
    end

    assign rd_data_o = state_q;
    assign abort_o   = !ext_rst_n_i && !state_q.day[DAY_RST_BIT];

    assert_unused_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_data_o & ~WR_MASK) == '0);

    assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !load_i) |=> $stable(rd_data_o));

    assert_halt_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (osc_stop_q && !load_i) |=> $stable(rd_data_o));

    assert_load_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> rd_data_o == $past(load_data_i & WR_MASK));

    assert_hund_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !load_i && !osc_stop_q && state_q.hundredths == 8'h09)
        |=> state_q.hundredths == 8'h10);

    assert_abort_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q.day[DAY_RST_BIT] |-> !abort_o);
endmodule

// File: tb/rtc_core_tb.sv
module rtc_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        ext_rst_n = 1'b1;
    logic        load = 1'b0;
    logic [63:0] load_data = '0;
    logic [63:0] rd_data;
    logic        abort;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    rtc_core u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .tick_i     (tick),
        .ext_rst_n_i(ext_rst_n),
        .load_i     (load),
        .load_data_i(load_data),
        .rd_data_o  (rd_data),
        .abort_o    (abort)
    );

    // Word layout: year, month, date, day, hours, minutes, seconds, hundredths.
    localparam int NV = 16;
    localparam logic [63:0] VIN [NV] = '{
        64'h00_01_01_11_00_00_00_09, // R2 hundredths 09 -> 10
        64'h00_01_01_11_12_59_59_99, // R2 ripple into hours
        64'h00_01_01_11_19_59_59_99, // R3 19 -> 20
        64'h00_01_05_17_23_59_59_99, // R3 R6 midnight, weekday 7 -> 1
        64'h00_01_01_11_91_59_59_99, // R4 11 AM -> 12 PM
        64'h00_01_10_13_B1_59_59_99, // R4 11 PM -> 12 AM, next day
        64'h00_01_01_11_B2_59_59_99, // R4 12 PM -> 01 PM
        64'h23_04_30_11_23_59_59_99, // R5 30-day month
        64'h23_02_28_11_23_59_59_99, // R5 non-leap Feb
        64'h24_02_28_11_23_59_59_99, // R5 leap Feb
        64'h00_02_29_11_23_59_59_99, // R5 year 00 Feb 29 end
        64'h99_12_31_11_23_59_59_99, // R5 year end 99 -> 00
        64'h05_01_31_11_23_59_59_99, // R5 31-day month
        64'h10_02_28_11_23_59_59_99, // R5 odd tens, units 0 not leap
        64'h16_02_28_11_23_59_59_99, // R5 odd tens, units 6 leap
        64'h00_01_01_11_09_59_59_99  // R3 09 -> 10
    };
    localparam logic [63:0] VEXP [NV] = '{
        64'h00_01_01_11_00_00_00_10,
        64'h00_01_01_11_13_00_00_00,
        64'h00_01_01_11_20_00_00_00,
        64'h00_01_06_11_00_00_00_00,
        64'h00_01_01_11_B2_00_00_00,
        64'h00_01_11_14_92_00_00_00,
        64'h00_01_01_11_A1_00_00_00,
        64'h23_05_01_12_00_00_00_00,
        64'h23_03_01_12_00_00_00_00,
        64'h24_02_29_12_00_00_00_00,
        64'h00_03_01_12_00_00_00_00,
        64'h00_01_01_12_00_00_00_00,
        64'h05_02_01_12_00_00_00_00,
        64'h10_03_01_12_00_00_00_00,
        64'h16_02_29_12_00_00_00_00,
        64'h00_01_01_11_10_00_00_00
    };
    localparam int VREQ [NV] = '{2, 2, 3, 3, 4, 4, 4, 5, 5, 5, 5, 5, 5, 5, 5, 3};

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic do_load(input logic [63:0] d);
        @(negedge clk);
        load = 1'b1;
        load_data = d;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset word", rd_data, 64'h00_01_01_31_00_00_00_00);
        ext_rst_n = 1'b0;
        #1;
        check("R1 abort low after reset", {63'd0, abort}, 64'd0);
        ext_rst_n = 1'b1;
        do_tick();
        check("R7 halted after reset", rd_data, 64'h00_01_01_31_00_00_00_00);

        for (int i = 0; i < NV; i++) begin
            do_load(VIN[i]);
            do_tick();
            check($sformatf("R%0d vector %0d", VREQ[i], i), rd_data, VEXP[i]);
        end

        // R2: no tick, word holds
        do_load(64'h00_01_01_11_00_00_00_42);
        repeat (4) @(negedge clk);
        check("R2 hold without tick", rd_data, 64'h00_01_01_11_00_00_00_42);

        // R10: unused bits dropped; day bit5 set so tick then ignored (R7)
        do_load(64'hFF_FF_FF_FF_FF_FF_FF_FF);
        check("R10 masked load", rd_data, 64'hFF_1F_3F_37_BF_7F_7F_FF);
        do_tick();
        check("R7 tick ignored when halted", rd_data, 64'hFF_1F_3F_37_BF_7F_7F_FF);

        // R9: load and tick in the same cycle, load wins
        @(negedge clk);
        load = 1'b1;
        tick = 1'b1;
        load_data = 64'h00_01_01_11_00_00_00_09;
        @(negedge clk);
        load = 1'b0;
        tick = 1'b0;
        check("R9 load beats tick", rd_data, 64'h00_01_01_11_00_00_00_09);

        // R8: reset-enable bit 0, running clock
        do_load(64'h00_01_01_01_00_00_00_20);
        ext_rst_n = 1'b0;
        #1;
        check("R8 abort asserted", {63'd0, abort}, 64'd1);
        @(negedge clk);
        check("R8 regs unchanged by ext reset", rd_data, 64'h00_01_01_01_00_00_00_20);
        ext_rst_n = 1'b1;
        #1;
        check("R8 abort released", {63'd0, abort}, 64'd0);
        do_load(64'h00_01_01_11_00_00_00_20);
        ext_rst_n = 1'b0;
        #1;
        check("R8 abort ignored with bit4 set", {63'd0, abort}, 64'd0);
        ext_rst_n = 1'b1;

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog got=timeout expected=completion");
        finish_run();
    end
endmodule